// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Pin Interrupt Detection

This block serves one bank of general-purpose pins. Each pin's input is passed through a flop synchronizer, and software can read the result. Each pin can run in one of two ways. In plain mode, a pattern bit sets the level the block presents for that pin when the pin is an output. In interrupt mode, the same two pattern bits choose one trigger: a rising edge, a falling edge, a high level or a low level. When the trigger occurs, a pending flag is latched. An unmasked flag drives a single registered interrupt line toward a parent interrupt controller.

Software never writes a register word directly. Each configuration register and the flag register has two write aliases. A write to the set alias turns on every bit that is one in the data word. A write to the clear alias turns those bits off. Zero bits in the data leave the register unchanged. Reads return a whole 32-bit register at once, so a handler reads the flag word and services every pending pin in one pass. Writing a pin's bit to the flag clear alias acknowledges it. Several banks can share a bus: each bank answers only inside its own 256-byte window, selected by the address bits above bit 7.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_out` is zero and `irq_out` is low.
- R2: The address selects a register and an alias. Bits [7:4] select the register: 0 is the synchronized pin state (read only), 1 is the interrupt enable, 2 is the mask, 3 is the trigger-type bit, 4 is the polarity/output bit and 5 is the pending flags. Bits [3:0] select the alias: 4 sets the bits that are one in the data, and 8 clears them. A write with bits [3:0] equal to 0 changes nothing.
- R3: A read returns the selected register on `bus_rdata` one cycle after `bus_rd`. The pin-state register shows `pin_in` after the synchronizer stages.
- R4: A pin whose interrupt enable is 0 drives its polarity/output bit on `pin_out`. A pin in interrupt mode drives 0.
- R5: In interrupt mode, with the trigger-type bit 1 and the polarity bit 1, a rising edge of the synchronized input sets the pin's flag. The flag stays set after the input falls again.
- R6: In interrupt mode, with the trigger-type bit 1 and the polarity bit 0, only a falling edge sets the flag. A rising edge leaves the flag clear.
- R7: In interrupt mode, with the trigger-type bit 0, the flag sets while the synchronized input equals the polarity bit. If the flag is cleared while that level persists, the flag sets again one cycle later.
- R8: A pin whose interrupt enable is 0 never sets its flag from input activity.
- R9: A masked pin still latches its flag but cannot raise `irq_out`. Clearing the mask bit lets the pending flag through.
- R10: `irq_out` is registered. It equals the OR over all pins of (flag AND NOT mask) from the previous cycle, so it rises one cycle after a flag sets.
- R11: A write of ones to the flag clear alias clears those flags. It takes priority over a trigger in the same cycle.
- R12: Writes whose address bits above bit 7 do not equal the bank index have no effect, and reads at such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns all state to zero |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears next cycle |
| bus_addr | input | ADDR_W | Byte address: bank index, register index, alias |
| bus_wdata | input | DATA_W | Write data, one bit per pin |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Output level per pin while not in interrupt mode |
| irq_out | output | 1 | Aggregated interrupt toward the parent controller |

## Verification
The hardest case to reach is a level flag that software clears while its level is still present. The clear and the renewed trigger meet in the same cycle, and the flag is low for only one cycle. The stimulus holds a high level on a level-high pin and issues the clear through the normal write path. It then samples `irq_out` on each of the next cycles and expects high, low, high, because the output register shows the one-cycle gap. The edge cases are reached the same way: the bench moves a single input bit between negative clock edges and counts the two synchronizer stages, the flag stage and the output stage before it samples.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // register indices, address bits [7:4]
   localparam logic [3:0] IDX_PIN  = 4'd0;
   localparam logic [3:0] IDX_INT  = 4'd1;
   localparam logic [3:0] IDX_MASK = 4'd2;
   localparam logic [3:0] IDX_PAT1 = 4'd3;
   localparam logic [3:0] IDX_PAT0 = 4'd4;
   localparam logic [3:0] IDX_FLAG = 4'd5;
   localparam int REG_CNT = 6;
   localparam int IDX_W   = $clog2(REG_CNT);

   // write aliases, address bits [3:0]
   localparam logic [3:0] ALIAS_SET = 4'h4;
   localparam logic [3:0] ALIAS_CLR = 4'h8;

   // configuration register slots, ordered as their indices from IDX_INT
   localparam int CFG_INT  = 0;
   localparam int CFG_MASK = 1;
   localparam int CFG_PAT1 = 2;
   localparam int CFG_PAT0 = 3;
   localparam int CFG_CNT  = 4;

   // trigger condition for one pin
   function automatic logic pin_trigger(input logic smp, input logic prev,
                                        input logic edge_mode, input logic pol);
      logic hit;
      if (edge_mode) hit = pol ? (smp & ~prev) : (~smp & prev);
      else           hit = (smp == pol);
      return hit;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | bits;
      else if (clr_en) q <= q & ~bits;
   end
endmodule

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
   import gpio_irq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int BANK_IDX = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr,
   input  logic                           bus_rd,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [REG_CNT-1:0][DATA_W-1:0] rd_bank,
   output logic [CFG_CNT-1:0]             cfg_set,
   output logic [CFG_CNT-1:0]             cfg_clr,
   output logic                           flag_set,
   output logic                           flag_clr,
   output logic [DATA_W-1:0]              bus_rdata
);
   localparam int BANK_W = ADDR_W - 8;
   localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_IDX);

   logic       bank_hit, wr_set, wr_clr, rd_ok;
   logic [3:0] reg_sel, alias_sel;

   assign bank_hit  = (bus_addr[ADDR_W-1:8] == BANK_SEL);
   assign reg_sel   = bus_addr[7:4];
   assign alias_sel = bus_addr[3:0];
   assign wr_set    = bus_wr & bank_hit & (alias_sel == ALIAS_SET);
   assign wr_clr    = bus_wr & bank_hit & (alias_sel == ALIAS_CLR);

   for (genvar k = 0; k < CFG_CNT; k++) begin : g_cfg_dec
      assign cfg_set[k] = wr_set & (reg_sel == IDX_INT + 4'(k));
      assign cfg_clr[k] = wr_clr & (reg_sel == IDX_INT + 4'(k));
   end

   assign flag_set = wr_set & (reg_sel == IDX_FLAG);
   assign flag_clr = wr_clr & (reg_sel == IDX_FLAG);

   assign rd_ok = bank_hit & (reg_sel < 4'(REG_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_ok ? rd_bank[reg_sel[IDX_W-1:0]] : '0;
   end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
   import gpio_irq_pkg::*;
#(
   parameter int N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] smp,
   input  logic [N_PINS-1:0] int_en,
   input  logic [N_PINS-1:0] edge_mode,
   input  logic [N_PINS-1:0] pol,
   input  logic [N_PINS-1:0] sw_set,
   input  logic [N_PINS-1:0] sw_clr,
   output logic [N_PINS-1:0] flag
);
   logic [N_PINS-1:0] prev_q;
   logic [N_PINS-1:0] trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign trig[p] = int_en[p] & pin_trigger(smp[p], prev_q[p], edge_mode[p], pol[p]);

      // acknowledge wins over a trigger in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   flag[p] <= 1'b0;
         else if (sw_clr[p])           flag[p] <= 1'b0;
         else if (trig[p] | sw_set[p]) flag[p] <= 1'b1;
      end
   end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int N_PINS         = 32,
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 12,
   parameter int BANK_IDX       = 0,
   parameter int SYNC_STAGES    = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pin_in,
   output logic [N_PINS-1:0] pin_out,
   output logic              irq_out
);
   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_irq_bank: N_PINS must be between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_bank: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must leave room for a bank index");
   end
   if (BANK_IDX < 0 || BANK_IDX >= (1 << (ADDR_W - 8))) begin : g_bad_bank
      $error("gpio_irq_bank: BANK_IDX does not fit above the bank window");
   end

   logic [N_PINS-1:0]              wbits;
   logic [N_PINS-1:0]              smp_q;
   logic [CFG_CNT-1:0]             cfg_set, cfg_clr;
   logic                           flag_set, flag_clr;
   logic [CFG_CNT-1:0][N_PINS-1:0] cfg_q;
   logic [N_PINS-1:0]              int_q, mask_q, pat1_q, pat0_q, flag_q;
   logic [REG_CNT-1:0][DATA_W-1:0] rd_bank;
   logic                           irq_any;

   assign wbits = bus_wdata[N_PINS-1:0];

   gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp_q)
   );

   gpio_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_IDX(BANK_IDX)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .rd_bank   (rd_bank),
      .cfg_set   (cfg_set),
      .cfg_clr   (cfg_clr),
      .flag_set  (flag_set),
      .flag_clr  (flag_clr),
      .bus_rdata (bus_rdata)
   );

   for (genvar k = 0; k < CFG_CNT; k++) begin : g_cfg
      gpio_setclr_reg #(.W(N_PINS)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (cfg_set[k]),
         .clr_en (cfg_clr[k]),
         .bits   (wbits),
         .q      (cfg_q[k])
      );
   end

   assign int_q  = cfg_q[CFG_INT];
   assign mask_q = cfg_q[CFG_MASK];
   assign pat1_q = cfg_q[CFG_PAT1];
   assign pat0_q = cfg_q[CFG_PAT0];

   gpio_trig #(.N_PINS(N_PINS)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp       (smp_q),
      .int_en    (int_q),
      .edge_mode (pat1_q),
      .pol       (pat0_q),
      .sw_set    ({N_PINS{flag_set}} & wbits),
      .sw_clr    ({N_PINS{flag_clr}} & wbits),
      .flag      (flag_q)
   );

   assign rd_bank[IDX_PIN]  = DATA_W'(smp_q);
   assign rd_bank[IDX_INT]  = DATA_W'(int_q);
   assign rd_bank[IDX_MASK] = DATA_W'(mask_q);
   assign rd_bank[IDX_PAT1] = DATA_W'(pat1_q);
   assign rd_bank[IDX_PAT0] = DATA_W'(pat0_q);
   assign rd_bank[IDX_FLAG] = DATA_W'(flag_q);

   assign pin_out = pat0_q & ~int_q;
   assign irq_any = |(flag_q & ~mask_q);

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= irq_any;
      end
   end else begin : g_irq_comb
      assign irq_out = irq_any;
   end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_irq_pkg::*;
#(
   parameter int N_PINS         = 32,
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 12,
   parameter int BANK_IDX       = 0,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_out,
   input logic [N_PINS-1:0] int_q,
   input logic [N_PINS-1:0] mask_q,
   input logic [N_PINS-1:0] flag_q
);
   localparam int BANK_W = ADDR_W - 8;

   logic              in_bank;
   logic              ack_wr, fset_wr, mset_wr;
   logic [N_PINS-1:0] wb;
   logic              pend;

   assign in_bank = (bus_addr[ADDR_W-1:8] == BANK_W'(BANK_IDX));
   assign ack_wr  = bus_wr & in_bank & (bus_addr[7:0] == {IDX_FLAG, ALIAS_CLR});
   assign fset_wr = bus_wr & in_bank & (bus_addr[7:0] == {IDX_FLAG, ALIAS_SET});
   assign mset_wr = bus_wr & in_bank & (bus_addr[7:0] == {IDX_MASK, ALIAS_SET});
   assign wb      = bus_wdata[N_PINS-1:0];
   assign pend    = |(flag_q & ~mask_q);

   if (IRQ_REGISTERED) begin : g_reg_chk
      // R10: unmasked pending flag raises the line one cycle later
      a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
         pend |=> irq_out);
      // R9, R10: with nothing unmasked pending, the line is low next cycle
      a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !pend |=> !irq_out);
   end

   // R11: acknowledged bits are clear after the write
   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> ((flag_q & $past(wb)) == '0));

   // R2: set alias turns on every written one
   a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      mset_wr |=> ((mask_q & $past(wb)) == $past(wb)));

   // R8: a new flag needs interrupt mode, or a software set
   a_r8_no_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !fset_wr |=> ((flag_q & ~$past(flag_q) & ~$past(int_q)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
   .N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .BANK_IDX(BANK_IDX), .IRQ_REGISTERED(IRQ_REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out),
   .int_q     (int_q),
   .mask_q    (mask_q),
   .flag_q    (flag_q)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
   localparam logic [11:0] A_PIN  = 12'h000;
   localparam logic [11:0] A_INT  = 12'h010;
   localparam logic [11:0] A_MASK = 12'h020;
   localparam logic [11:0] A_PAT1 = 12'h030;
   localparam logic [11:0] A_PAT0 = 12'h040;
   localparam logic [11:0] A_FLAG = 12'h050;
   localparam logic [11:0] SETA   = 12'h004;
   localparam logic [11:0] CLRA   = 12'h008;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic        irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic rd_seen = 1'b0;
   rd_item_t rq[$];

   always #2 clk = ~clk;

   gpio_irq_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: read data is due one cycle after the strobe
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (rq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R3 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            rd_item_t it;
            it = rq.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.exp = exp; it.tag = tag;
      rq.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
      chk("R1 pin_out", pin_out, 32'd0);
      rd(A_INT,  32'd0, "R1 int reg");
      rd(A_MASK, 32'd0, "R1 mask reg");
      rd(A_PAT1, 32'd0, "R1 pat1 reg");
      rd(A_PAT0, 32'd0, "R1 pat0 reg");
      rd(A_FLAG, 32'd0, "R1 flag reg");

      // R2: aliases, base offset ignored
      wr(A_PAT0 | SETA, 32'h0000_00F0);
      rd(A_PAT0, 32'h0000_00F0, "R2 set alias");
      chk("R4 plain pins drive pattern", pin_out, 32'h0000_00F0);
      wr(A_PAT0, 32'hFFFF_FFFF);
      rd(A_PAT0, 32'h0000_00F0, "R2 base write ignored");
      wr(A_PAT0 | CLRA, 32'h0000_0030);
      rd(A_PAT0, 32'h0000_00C0, "R2 clear alias");

      // R12: other bank
      wr(12'h140 | SETA, 32'hFFFF_FFFF);
      rd(A_PAT0, 32'h0000_00C0, "R12 foreign write ignored");
      rd(12'h140, 32'd0, "R12 foreign read zero");
      wr(A_PAT0 | CLRA, 32'h0000_00C0);

      // R3: synchronized pin state
      pin_in = 32'hA5A5_0000;
      idle(3);
      rd(A_PIN, 32'hA5A5_0000, "R3 pin state");
      pin_in = '0;
      idle(3);

      // R8: rising config without interrupt mode
      wr(A_PAT1 | SETA, 32'h1);
      wr(A_PAT0 | SETA, 32'h1);
      chk("R4 pin0 drives pattern", pin_out, 32'h1);
      pin_in[0] = 1'b1;
      idle(4);
      rd(A_FLAG, 32'd0, "R8 no flag without int mode");
      chk("R8 irq stays low", {31'd0, irq_out}, 32'd0);
      pin_in[0] = 1'b0;
      idle(4);

      // R5, R10: rising edge
      wr(A_INT | SETA, 32'h1);
      chk("R4 int pin drives zero", pin_out, 32'd0);
      pin_in[0] = 1'b1;
      idle(3);
      chk("R10 irq not yet", {31'd0, irq_out}, 32'd0);
      idle(1);
      chk("R10 irq one cycle after flag", {31'd0, irq_out}, 32'd1);
      pin_in[0] = 1'b0;
      idle(4);
      rd(A_FLAG, 32'h1, "R5 edge flag held");
      chk("R5 irq held", {31'd0, irq_out}, 32'd1);

      // R11: acknowledge
      wr(A_FLAG | CLRA, 32'h1);
      idle(2);
      chk("R11 irq drops after ack", {31'd0, irq_out}, 32'd0);
      rd(A_FLAG, 32'd0, "R11 flag cleared");

      // R6: falling edge on pin 1
      wr(A_PAT1 | SETA, 32'h2);
      wr(A_INT | SETA, 32'h2);
      pin_in[1] = 1'b1;
      idle(4);
      rd(A_FLAG, 32'd0, "R6 rising ignored");
      pin_in[1] = 1'b0;
      idle(4);
      rd(A_FLAG, 32'h2, "R6 falling sets flag");
      chk("R6 irq", {31'd0, irq_out}, 32'd1);
      wr(A_FLAG | CLRA, 32'h2);
      idle(2);

      // R9: masked level-high pin 2
      wr(A_PAT0 | SETA, 32'h4);
      wr(A_MASK | SETA, 32'h4);
      wr(A_INT | SETA, 32'h4);
      pin_in[2] = 1'b1;
      idle(4);
      rd(A_FLAG, 32'h4, "R9 masked flag latched");
      chk("R9 masked irq low", {31'd0, irq_out}, 32'd0);
      wr(A_MASK | CLRA, 32'h4);
      idle(1);
      chk("R9 unmask passes flag", {31'd0, irq_out}, 32'd1);

      // R7: clear while level persists
      wr(A_FLAG | CLRA, 32'h4);
      chk("R7 irq during ack", {31'd0, irq_out}, 32'd1);
      idle(1);
      chk("R7 R11 one-cycle gap", {31'd0, irq_out}, 32'd0);
      idle(1);
      chk("R7 level re-sets", {31'd0, irq_out}, 32'd1);
      pin_in[2] = 1'b0;
      idle(4);
      wr(A_FLAG | CLRA, 32'h4);
      idle(3);
      rd(A_FLAG, 32'd0, "R7 level gone stays clear");
      chk("R7 irq low", {31'd0, irq_out}, 32'd0);

      // R7: level low on pin 3
      pin_in[3] = 1'b1;
      idle(4);
      wr(A_INT | SETA, 32'h8);
      idle(3);
      rd(A_FLAG, 32'd0, "R7 low level not met");
      pin_in[3] = 1'b0;
      idle(4);
      rd(A_FLAG, 32'h8, "R7 low level sets");
      wr(A_INT | CLRA, 32'h8);
      wr(A_FLAG | CLRA, 32'h8);
      idle(2);
      rd(A_FLAG, 32'd0, "R7 low flag acked");

      // R2: software set of a flag
      wr(A_FLAG | SETA, 32'h8000_0000);
      idle(1);
      chk("R2 flag set alias irq", {31'd0, irq_out}, 32'd1);
      rd(A_FLAG, 32'h8000_0000, "R2 flag set alias");
      wr(A_FLAG | CLRA, 32'h8000_0000);
      rd(A_INT, 32'h0000_0007, "R2 int reg after aliases");
      rd(A_MASK, 32'd0, "R2 mask reg after aliases");

      idle(3);
      if (rq.size() != 0) begin
         checks++; errors++;
         $display("FAIL R3 reads outstanding actual=%0d expected=0", rq.size());
      end
      finish_run();
   end
endmodule